// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Driver Controller

This block sits between a processor's port registers and the pad drivers of a group of general-purpose pins. For every pin it keeps an output latch that software writes. From that latch, it produces three driver enables: an n-channel pull-down, a strong p-channel pull-up and a weak keeper pull-up. It runs on the oscillator clock. Each pin carries a fixed mask option chosen by parameter: quasi-bidirectional, open-drain or push-pull. Each pin also has a fixed level that its latch takes at reset. The sensed pad level passes through a two-flop synchronizer. The synchronized level is returned to software and also feeds the keeper logic.

In quasi-bidirectional mode, a rising output level fires a short strong pull-up pulse that charges the pad. After the pulse, the keeper holds the 1 for as long as the synchronized pad reads high. An alternate-function output is ANDed with the latch, so it reaches the pad only while the latch holds 1. One instance can be built as the multiplexed address/data port. That variant has no keeper, and during external memory cycles it takes its level from the bus value, using a separate rule set. It raises an error flag if a push-pull pin is used for an external memory access.

Top module: `qbp_port`

## Requirements
- R1: On a synchronous reset each latch bit takes its RST_LEVEL bit, and all three enables, pin_rd and cfg_err are 0 while rst is high. A cycle with wr_en high loads all latch bits from wr_data. Every enable is registered, so it reflects the latch and input state one clock edge later.
- R2: A pin's mode is PIN_MODE[2i+1:2i], encoded 0 quasi-bidirectional, 1 open-drain, 2 push-pull and 3 treated as open-drain. For a quasi pin in I/O mode, a 0-to-1 change of its effective level sampled at edge E0 raises spu_en after edges E1 and E2 (for PULSE_LEN=2) and clears it after E3.
- R3: Writing 1 to a quasi pin whose latch already holds 1 fires no new strong pulse.
- R4: When a 0 is written during a strong pulse, the next clock edge clears spu_en and sets pd_en.
- R5: A quasi pin on a general port has wpu_en high exactly when its effective level is 1 and its synchronized pad level is 1.
- R6: An open-drain pin drives pd_en equal to the inverse of its effective level, and it never enables spu_en or wpu_en.
- R7: A push-pull pin drives pd_en = NOT level and spu_en = level, and it never enables wpu_en.
- R8: The effective level is latch AND alt_out. A rise caused by alt_out going high also fires the strong pulse.
- R9: Pins marked in NO_PULL never assert spu_en or wpu_en in any mode.
- R10: pin_rd equals pin_in as sampled two clock edges earlier.
- R11: With ADDR_DATA_PORT=1 and ext_mem low, wpu_en is never asserted. Quasi pins still get the strong pulse.
- R12: With ADDR_DATA_PORT=1 and ext_mem high, the pin level is latch AND bus_out. Quasi pins drive it both ways with pd_en/spu_en, and open-drain pins drive only pd_en. Push-pull pins release all enables, and cfg_err is 1. A general port ignores ext_mem and bus_out, and its cfg_err stays 0.
- R13: pd_en and spu_en are never both high on the same pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | N_PINS | Value written to the latches |
| alt_out | input | N_PINS | Alternate-function output, tie high when unused |
| ext_mem | input | 1 | External memory cycle in progress (address/data port only) |
| bus_out | input | N_PINS | Address/data value during an external memory cycle |
| pin_in | input | N_PINS | Raw sensed pad level |
| pin_rd | output | N_PINS | Synchronized pad level |
| pd_en | output | N_PINS | Pull-down driver enable |
| spu_en | output | N_PINS | Strong pull-up enable |
| wpu_en | output | N_PINS | Weak keeper pull-up enable |
| cfg_err | output | 1 | Push-pull pin used during an external memory cycle |

## Verification
The bench builds two instances. The first is an 8-pin general port that mixes quasi, open-drain and push-pull pins with mixed reset levels and two no-pull pins. With a bench pad model that keeps a floating pin at its last level, this instance shows the keeper holding a pulsed 1, losing it when the pad is pulled low, and failing to recover when the latch is rewritten. The second is a 4-pin address/data port that includes a push-pull pin, which exercises the missing keeper, the bus-driven two-way drive and the illegal-option flag. PULSE_LEN is 2 in both instances, so the pulse window and the cancel case can be counted edge by edge.

// File: rtl/qbp_pkg.sv
`timescale 1ns/1ps
package qbp_pkg;
  typedef enum logic [1:0] {
    PM_QUASI = 2'd0,
    PM_OPEN  = 2'd1,
    PM_PUSH  = 2'd2,
    PM_RSVD  = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic pd;
    logic spu;
    logic wpu;
  } drive_t;
endpackage

// File: rtl/qbp_sync.sv
`timescale 1ns/1ps
module qbp_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/qbp_pulse.sv
`timescale 1ns/1ps
module qbp_pulse #(
  parameter int PULSE_LEN = 2,
  parameter bit RST_VAL   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic active
);
  localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise   = lvl & ~lvl_q;
  assign active = lvl & (rise | (cnt_q != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= RST_VAL;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl;
      if (!lvl)
        cnt_q <= '0;
      else if (rise)
        cnt_q <= CW'(PULSE_LEN - 1);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/qbp_drive.sv
`timescale 1ns/1ps
module qbp_drive
  import qbp_pkg::*;
#(
  parameter logic [1:0] MODE      = 2'd0,
  parameter bit         NOPULL    = 1'b0,
  parameter bit         ADDR_PORT = 1'b0
) (
  input  logic   lvl,
  input  logic   pulse,
  input  logic   pin_s,
  input  logic   ext_mem,
  input  logic   bus_lvl,
  output drive_t drv
);
  localparam pin_mode_e PM = pin_mode_e'(MODE);

  always_comb begin
    drv = '0;
    if (ADDR_PORT && ext_mem) begin
      case (PM)
        PM_QUASI: begin
          drv.pd  = ~bus_lvl;
          drv.spu = bus_lvl;
        end
        PM_PUSH: begin
          drv.pd  = 1'b0;
        end
        default: begin
          drv.pd  = ~bus_lvl;
        end
      endcase
    end else begin
      drv.pd = ~lvl;
      case (PM)
        PM_QUASI: begin
          drv.spu = lvl & pulse;
          drv.wpu = ADDR_PORT ? 1'b0 : (lvl & pin_s);
        end
        PM_PUSH: begin
          drv.spu = lvl;
        end
        default: begin
          drv.spu = 1'b0;
        end
      endcase
    end
    if (NOPULL) begin
      drv.spu = 1'b0;
      drv.wpu = 1'b0;
    end
  end
endmodule

// File: rtl/qbp_port.sv
`timescale 1ns/1ps
module qbp_port
  import qbp_pkg::*;
#(
  parameter int                  N_PINS         = 8,
  parameter logic [2*N_PINS-1:0] PIN_MODE       = '0,
  parameter logic [N_PINS-1:0]   RST_LEVEL      = '1,
  parameter logic [N_PINS-1:0]   NO_PULL        = '0,
  parameter bit                  ADDR_DATA_PORT = 1'b0,
  parameter int                  PULSE_LEN      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [N_PINS-1:0] wr_data,
  input  logic [N_PINS-1:0] alt_out,
  input  logic              ext_mem,
  input  logic [N_PINS-1:0] bus_out,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_rd,
  output logic [N_PINS-1:0] pd_en,
  output logic [N_PINS-1:0] spu_en,
  output logic [N_PINS-1:0] wpu_en,
  output logic              cfg_err
);
  function automatic bit any_push(input logic [2*N_PINS-1:0] modes);
    bit found = 1'b0;
    for (int k = 0; k < N_PINS; k++)
      if (modes[2*k +: 2] == PM_PUSH) found = 1'b1;
    return found;
  endfunction

  localparam bit HAS_PUSH = any_push(PIN_MODE);

  logic [N_PINS-1:0] latch_q;
  logic [N_PINS-1:0] eff_lvl;
  logic [N_PINS-1:0] bus_lvl;
  logic [N_PINS-1:0] pulse_on;
  drive_t            drv [N_PINS];

  always_ff @(posedge clk) begin
    if (rst)
      latch_q <= RST_LEVEL;
    else if (wr_en)
      latch_q <= wr_data;
  end

  assign eff_lvl = latch_q & alt_out;
  assign bus_lvl = latch_q & bus_out;

  qbp_sync #(.W(N_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_rd)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    qbp_pulse #(
      .PULSE_LEN (PULSE_LEN),
      .RST_VAL   (RST_LEVEL[i])
    ) u_pulse (
      .clk    (clk),
      .rst    (rst),
      .lvl    (eff_lvl[i]),
      .active (pulse_on[i])
    );

    qbp_drive #(
      .MODE      (PIN_MODE[2*i +: 2]),
      .NOPULL    (NO_PULL[i]),
      .ADDR_PORT (ADDR_DATA_PORT)
    ) u_drive (
      .lvl     (eff_lvl[i]),
      .pulse   (pulse_on[i]),
      .pin_s   (pin_rd[i]),
      .ext_mem (ext_mem),
      .bus_lvl (bus_lvl[i]),
      .drv     (drv[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        pd_en[i]  <= 1'b0;
        spu_en[i] <= 1'b0;
        wpu_en[i] <= 1'b0;
      end else begin
        pd_en[i]  <= drv[i].pd;
        spu_en[i] <= drv[i].spu;
        wpu_en[i] <= drv[i].wpu;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_err <= 1'b0;
    else
      cfg_err <= ADDR_DATA_PORT && HAS_PUSH && ext_mem;
  end
endmodule

// File: rtl/qbp_port_chk.sv
`timescale 1ns/1ps
module qbp_port_chk
  import qbp_pkg::*;
#(
  parameter int                  N_PINS         = 8,
  parameter logic [2*N_PINS-1:0] PIN_MODE       = '0,
  parameter logic [N_PINS-1:0]   NO_PULL        = '0,
  parameter bit                  ADDR_DATA_PORT = 1'b0,
  parameter int                  PULSE_LEN      = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_mem,
  input logic [N_PINS-1:0] pin_in,
  input logic [N_PINS-1:0] pin_rd,
  input logic [N_PINS-1:0] pd_en,
  input logic [N_PINS-1:0] spu_en,
  input logic [N_PINS-1:0] wpu_en,
  input logic              cfg_err
);
  localparam int RW = $clog2(PULSE_LEN + 2) + 1;

  logic [1:0]        cyc_q;
  logic              em_q;
  logic [N_PINS-1:0] quasi_m, open_m, push_m;
  logic              io_ok;

  for (genvar i = 0; i < N_PINS; i++) begin : g_mask
    assign quasi_m[i] = (PIN_MODE[2*i +: 2] == PM_QUASI);
    assign open_m[i]  = (PIN_MODE[2*i +: 2] == PM_OPEN) || (PIN_MODE[2*i +: 2] == PM_RSVD);
    assign push_m[i]  = (PIN_MODE[2*i +: 2] == PM_PUSH) && !NO_PULL[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      em_q  <= 1'b0;
    end else begin
      if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
      em_q <= ext_mem;
    end
  end

  assign io_ok = !ADDR_DATA_PORT || (!ext_mem && !em_q);

  for (genvar i = 0; i < N_PINS; i++) begin : g_run
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
      if (rst)
        run_q <= '0;
      else if (spu_en[i] && quasi_m[i] && io_ok)
        run_q <= run_q + 1'b1;
      else
        run_q <= '0;
    end
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
      run_q <= RW'(PULSE_LEN)); // R2
  end

  AST_PD_SPU_EXCL: assert property (@(posedge clk) disable iff (rst)
    (pd_en & spu_en) == '0); // R13
  AST_NOPULL_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((spu_en | wpu_en) & NO_PULL) == '0); // R9
  AST_OPEN_NO_PULLUP: assert property (@(posedge clk) disable iff (rst)
    ((spu_en | wpu_en) & open_m) == '0); // R6
  AST_PUSH_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (cyc_q != 2'd0 && (!ADDR_DATA_PORT || !em_q)) |-> (((pd_en | spu_en) & push_m) == push_m)); // R7
  AST_RD_SYNC: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd2) |-> (pin_rd == $past(pin_in, 2))); // R10
  AST_ADDR_NO_WEAK: assert property (@(posedge clk) disable iff (rst)
    ADDR_DATA_PORT |-> (wpu_en == '0)); // R11
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> (ADDR_DATA_PORT && $past(ext_mem))); // R12
endmodule

bind qbp_port qbp_port_chk #(
  .N_PINS         (N_PINS),
  .PIN_MODE       (PIN_MODE),
  .NO_PULL        (NO_PULL),
  .ADDR_DATA_PORT (ADDR_DATA_PORT),
  .PULSE_LEN      (PULSE_LEN)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ext_mem (ext_mem),
  .pin_in  (pin_in),
  .pin_rd  (pin_rd),
  .pd_en   (pd_en),
  .spu_en  (spu_en),
  .wpu_en  (wpu_en),
  .cfg_err (cfg_err)
);

// File: tb/qbp_port_bench.sv
`timescale 1ns/1ps
module qbp_port_bench;
  // Pin modes: 0 quasi, 1 open-drain, 2 push-pull (R2)
  // General port pins 7..0: quasi, push, open, open, quasi, quasi, quasi, quasi
  localparam logic [15:0] G_MODE  = 16'h2500;
  localparam logic [7:0]  G_RST   = 8'h5F;
  localparam logic [7:0]  G_NOPUL = 8'h88;
  // Address/data port pins 3..0: push, open, quasi, quasi
  localparam logic [7:0]  A_MODE  = 8'h90;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0, alt_out = 8'hFF, bus_out = '0, ext_lo = '0;
  logic       ext_mem = 1'b0;
  logic [7:0] pin_lvl = G_RST;
  logic [7:0] pin_rd, pd_en, spu_en, wpu_en;
  logic       cfg_err;

  logic       a_wr_en = 1'b0;
  logic [3:0] a_wr_data = '0, a_bus = '0;
  logic       a_ext_mem = 1'b0;
  logic [3:0] a_pin = 4'hF;
  logic [3:0] a_rd, a_pd, a_spu, a_wpu;
  logic       a_err;

  qbp_port #(
    .N_PINS(8), .PIN_MODE(G_MODE), .RST_LEVEL(G_RST), .NO_PULL(G_NOPUL),
    .ADDR_DATA_PORT(1'b0), .PULSE_LEN(2)
  ) u_qbp_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .alt_out(alt_out),
    .ext_mem(ext_mem), .bus_out(bus_out), .pin_in(pin_lvl), .pin_rd(pin_rd),
    .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en), .cfg_err(cfg_err)
  );

  qbp_port #(
    .N_PINS(4), .PIN_MODE(A_MODE), .RST_LEVEL(4'h0), .NO_PULL(4'h0),
    .ADDR_DATA_PORT(1'b1), .PULSE_LEN(2)
  ) u_qbp_port_ad (
    .clk(clk), .rst(rst), .wr_en(a_wr_en), .wr_data(a_wr_data), .alt_out(4'hF),
    .ext_mem(a_ext_mem), .bus_out(a_bus), .pin_in(a_pin), .pin_rd(a_rd),
    .pd_en(a_pd), .spu_en(a_spu), .wpu_en(a_wpu), .cfg_err(a_err)
  );

  // Pad model: external pull-low wins, then the drivers, else the pad keeps its level
  always @(pd_en or spu_en or wpu_en or ext_lo) begin
    for (int i = 0; i < 8; i++) begin
      if (ext_lo[i])                pin_lvl[i] = 1'b0;
      else if (pd_en[i])            pin_lvl[i] = 1'b0;
      else if (spu_en[i] | wpu_en[i]) pin_lvl[i] = 1'b1;
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic a_write(input logic [3:0] v);
    @(negedge clk);
    a_wr_en = 1'b1;
    a_wr_data = v;
    @(posedge clk);
    #1 a_wr_en = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0] wr, alt, lo, pd, spu, wpu, rd;
  } vec_t;

  localparam vec_t VEC [0:6] = '{
    '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00},
    '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h40, 8'h07, 8'h47},
    '{8'hFF, 8'hFF, 8'h01, 8'h00, 8'h40, 8'h06, 8'h46},
    '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h40, 8'h06, 8'h46},
    '{8'hFF, 8'hFC, 8'h00, 8'h03, 8'h40, 8'h04, 8'h44},
    '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h40, 8'h07, 8'h47},
    '{8'h2F, 8'hFF, 8'h00, 8'hD0, 8'h00, 8'h07, 8'h07}
  };

  logic [7:0] snap_pd, snap_spu, snap_wpu, snap_rd;

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pd", pd_en, 8'h00);
    check("R1 reset spu", spu_en, 8'h00);
    check("R1 reset rd", pin_rd, 8'h00);
    check("R1 reset err", {7'd0, cfg_err}, 8'h00);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check("R1 reset level pd", pd_en, 8'hA0);
    check("R7 reset level spu", spu_en, 8'h40);
    check("R5 reset level wpu", wpu_en, 8'h07);
    check("R10 reset level rd", pin_rd, 8'h5F);
    check("R1 addr port reset pd", {4'd0, a_pd}, 8'h0F);

    // Table: R3 (v3), R5 (v1,v2,v3), R6, R7, R8 (v4,v5), R9 (pin3/pin7)
    for (int v = 0; v < 7; v++) begin
      @(negedge clk);
      alt_out = VEC[v].alt;
      ext_lo  = VEC[v].lo;
      do_write(VEC[v].wr);
      repeat (10) @(negedge clk);
      check($sformatf("R6 table %0d pd", v), pd_en, VEC[v].pd);
      check($sformatf("R7 table %0d spu", v), spu_en, VEC[v].spu);
      check($sformatf("R5 table %0d wpu", v), wpu_en, VEC[v].wpu);
      check($sformatf("R3 table %0d rd", v), pin_rd, VEC[v].rd);
    end

    // R10: two-edge synchronizer latency on push-pull pin 6
    do_write(8'h6F);
    repeat (8) @(negedge clk);
    ext_lo = 8'h40;
    @(negedge clk);
    check("R10 rd after one edge", {7'd0, pin_rd[6]}, 8'h01);
    @(negedge clk);
    check("R10 rd after two edges", {7'd0, pin_rd[6]}, 8'h00);
    ext_lo = 8'h00;
    repeat (4) @(negedge clk);

    // R2: strong pulse window on pin 0
    do_write(8'h6E);
    repeat (6) @(negedge clk);
    do_write(8'h6F);
    @(negedge clk);
    check("R2 pulse after E0", {7'd0, spu_en[0]}, 8'h00);
    @(negedge clk);
    check("R2 pulse after E1", {7'd0, spu_en[0]}, 8'h01);
    @(negedge clk);
    check("R2 pulse after E2", {7'd0, spu_en[0]}, 8'h01);
    @(negedge clk);
    check("R2 pulse after E3", {7'd0, spu_en[0]}, 8'h00);

    // R4: write 0 during the pulse
    do_write(8'h6E);
    repeat (6) @(negedge clk);
    do_write(8'h6F);
    wr_en = 1'b1;
    wr_data = 8'h6E;
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
    check("R4 pulse started", {6'd0, spu_en[0], pd_en[0]}, 8'h02);
    @(negedge clk);
    check("R4 pulse cancelled", {6'd0, spu_en[0], pd_en[0]}, 8'h01);

    // R12: general port ignores ext_mem and bus_out
    repeat (8) @(negedge clk);
    snap_pd = pd_en; snap_spu = spu_en; snap_wpu = wpu_en; snap_rd = pin_rd;
    ext_mem = 1'b1;
    bus_out = 8'h00;
    repeat (6) @(negedge clk);
    check("R12 general pd unchanged", pd_en, snap_pd);
    check("R12 general spu unchanged", spu_en, snap_spu);
    check("R12 general wpu unchanged", wpu_en, snap_wpu);
    check("R12 general rd unchanged", pin_rd, snap_rd);
    check("R12 general no err", {7'd0, cfg_err}, 8'h00);
    ext_mem = 1'b0;

    // R11: address/data port in I/O mode
    a_write(4'hF);
    @(negedge clk);
    @(negedge clk);
    check("R11 addr pulse after E1", {4'd0, a_spu}, 8'h0B);
    repeat (8) @(negedge clk);
    check("R11 addr settled spu", {4'd0, a_spu}, 8'h08);
    check("R11 addr no keeper", {4'd0, a_wpu}, 8'h00);
    check("R11 addr settled pd", {4'd0, a_pd}, 8'h00);

    // R12: external memory cycles
    @(negedge clk);
    a_ext_mem = 1'b1;
    a_bus = 4'b0101;
    repeat (3) @(negedge clk);
    check("R12 ext pd 0101", {4'd0, a_pd}, 8'h02);
    check("R12 ext spu 0101", {4'd0, a_spu}, 8'h01);
    check("R12 ext err", {7'd0, a_err}, 8'h01);
    a_bus = 4'b1010;
    repeat (3) @(negedge clk);
    check("R12 ext pd 1010", {4'd0, a_pd}, 8'h05);
    check("R12 ext spu 1010", {4'd0, a_spu}, 8'h02);
    check("R11 ext no keeper", {4'd0, a_wpu}, 8'h00);
    a_ext_mem = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 io err cleared", {7'd0, a_err}, 8'h00);
    check("R7 io push drives", {4'd0, a_spu}, 8'h08);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule